// File: doc/BRIEF.md
# Delayed Bus Parity Generator and Checker

This block produces and checks even parity for a multiplexed 32-bit address/data bus that has four command/byte-enable lines. Each bus clock, the surrounding transaction logic shows the block the address/data and command/byte-enable values. It also gives a phase strobe, an address-or-data flag and two role flags: whether this device is the initiator, and whether the transfer is a write. One clock later the block either drives the parity bit with its output enable, or it checks the parity bit received from the bus.

A three-state slot register holds the plan for the clock that follows a phase. The states are `SLOT_IDLE`, `SLOT_DRIVE` and `SLOT_CHECK`. On every edge the next state comes from the phase that was present. `SLOT_DRIVE` is taken for an address phase this device initiates, for an initiator write data phase, and for a target read data phase. `SLOT_CHECK` is taken for a target write data phase. `SLOT_IDLE` is taken for every other case and for cycles with no phase. Any state can move to any state on each edge.

In `SLOT_CHECK`, the received bit is compared with the parity held from the previous clock. A mismatch gives a one-clock error pulse on the next edge and sets a sticky status bit. Software clears that bit by writing a 1.

Top module: `bpar_unit`

## Requirements
- R1: The generated parity is the XOR of all 36 bits (`addr_data[31:0]` and `cmd_be[3:0]`), so the count of ones across those bits plus `par_out` is even. No byte-enable value masks any lane.
- R2: `par_oe` and `par_out` take effect exactly one clock after the phase they belong to. When `par_oe` is high, `par_out` holds the parity of the values sampled on the previous edge.
- R3: An address phase (`phase_is_addr`=1) with `is_initiator`=1 sets `par_oe` high on the next clock. An address phase with `is_initiator`=0 leaves it low.
- R4: A data phase (`phase_is_addr`=0) drives parity on the next clock when `is_initiator`=1 and `is_write`=1, or when `is_initiator`=0 and `is_write`=0.
- R5: A data phase with `is_initiator`=1 and `is_write`=0 (initiator read) does not drive parity. A data phase with `is_initiator`=0 and `is_write`=1 (target write) does not drive parity either.
- R6: A clock with `phase_valid`=0 leaves `par_oe` low on the next clock.
- R7: After a target write data phase, `par_in` is checked in the following clock. A mismatch raises `err_pulse` for exactly one clock, starting on the edge after that check clock.
- R8: A wrong `par_in` after any phase that is not a target write data phase, or after a clock with no phase, never raises `err_pulse`.
- R9: `err_sticky` sets with `err_pulse` and stays set until `err_clr`=1 is sampled. If a new error and a clear arrive on the same edge, the error wins.
- R10: While `rst_n`=0, `par_oe`, `par_out`, `err_pulse` and `err_sticky` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_data | input | 32 | Address/data bus value this clock |
| cmd_be | input | 4 | Command/byte-enable value this clock |
| phase_valid | input | 1 | A phase is present this clock |
| phase_is_addr | input | 1 | 1 = address phase, 0 = data phase |
| is_initiator | input | 1 | 1 = this device initiates the transaction |
| is_write | input | 1 | 1 = write transfer, 0 = read |
| par_in | input | 1 | Parity bit received from the bus |
| err_clr | input | 1 | Write-1 clear of the sticky error bit |
| par_out | output | 1 | Generated parity, one clock late |
| par_oe | output | 1 | Output enable for the parity bit |
| err_pulse | output | 1 | One-clock parity error pulse |
| err_sticky | output | 1 | Sticky parity error status |

## Verification
The hardest situations to reach are those where the check window overlaps the next phase. In one, a target write data phase is followed directly by another phase, so the same clock carries `par_in` for the old phase and the role inputs for the new one. In another, a clear lands on the same edge as a fresh error. The random stimulus mixes roles, directions and phase gaps clock by clock, and it flips `par_in` on about a quarter of clocks, in check slots and in other slots alike. This produces back-to-back check slots and corrupted bits in slots that must be ignored. Directed steps also force an error to coincide with `err_clr`, and they apply all-ones, all-zero and single-bit bus patterns to exercise the full 36-bit parity.

// File: rtl/bpar_pkg.sv
package bpar_pkg;
    // Plan for the clock that follows a phase
    typedef enum logic [1:0] {
        SLOT_IDLE  = 2'd0,
        SLOT_DRIVE = 2'd1,
        SLOT_CHECK = 2'd2
    } slot_e;
endpackage

// File: rtl/bpar_tree.sv
module bpar_tree #(
    parameter int AD_W   = 32,
    parameter int CBE_W  = 4,
    parameter int LANE_W = 8
) (
    input  logic [AD_W-1:0]  addr_data,
    input  logic [CBE_W-1:0] cmd_be,
    output logic             parity
);
    localparam int LANES = AD_W / LANE_W;

    logic [LANES-1:0] lane_x;

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            assign lane_x[g] = ^addr_data[g*LANE_W +: LANE_W];
        end
    endgenerate

    // Every lane and every command/enable bit counts, whatever the enables say
    assign parity = (^lane_x) ^ (^cmd_be);
endmodule

// File: rtl/bpar_role.sv
module bpar_role
    import bpar_pkg::*;
(
    input  logic  phase_valid,
    input  logic  phase_is_addr,
    input  logic  is_initiator,
    input  logic  is_write,
    output slot_e slot_next
);
    always_comb begin
        slot_next = SLOT_IDLE;
        if (phase_valid) begin
            if (phase_is_addr) begin
                if (is_initiator) slot_next = SLOT_DRIVE;
            end else begin
                unique case ({is_initiator, is_write})
                    2'b11:   slot_next = SLOT_DRIVE;  // initiator write
                    2'b00:   slot_next = SLOT_DRIVE;  // target read
                    2'b01:   slot_next = SLOT_CHECK;  // target write
                    default: slot_next = SLOT_IDLE;   // initiator read
                endcase
            end
        end
    end
endmodule

// File: rtl/bpar_unit.sv
module bpar_unit
    import bpar_pkg::*;
#(
    parameter int AD_W  = 32,
    parameter int CBE_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AD_W-1:0]  addr_data,
    input  logic [CBE_W-1:0] cmd_be,
    input  logic             phase_valid,
    input  logic             phase_is_addr,
    input  logic             is_initiator,
    input  logic             is_write,
    input  logic             par_in,
    input  logic             err_clr,
    output logic             par_out,
    output logic             par_oe,
    output logic             err_pulse,
    output logic             err_sticky
);
    slot_e slot_q, slot_d;
    logic  par_calc;
    logic  par_q;
    logic  err_q, sticky_q;
    logic  mismatch;

    bpar_tree #(.AD_W(AD_W), .CBE_W(CBE_W), .LANE_W(8)) tree_i (
        .addr_data (addr_data),
        .cmd_be    (cmd_be),
        .parity    (par_calc)
    );

    bpar_role role_i (
        .phase_valid   (phase_valid),
        .phase_is_addr (phase_is_addr),
        .is_initiator  (is_initiator),
        .is_write      (is_write),
        .slot_next     (slot_d)
    );

    // State register: plan and parity for the trailing clock
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q <= SLOT_IDLE;
            par_q  <= 1'b0;
        end else begin
            slot_q <= slot_d;
            par_q  <= par_calc;
        end
    end

    assign mismatch = (par_in != par_q);

    // Error pulse and sticky status
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q    <= 1'b0;
            sticky_q <= 1'b0;
        end else begin
            err_q <= (slot_q == SLOT_CHECK) && mismatch;
            if ((slot_q == SLOT_CHECK) && mismatch) sticky_q <= 1'b1;
            else if (err_clr)                        sticky_q <= 1'b0;
        end
    end

    // Outputs decoded from the slot state
    always_comb begin
        par_oe  = 1'b0;
        par_out = 1'b0;
        unique case (slot_q)
            SLOT_DRIVE: begin
                par_oe  = 1'b1;
                par_out = par_q;
            end
            SLOT_CHECK: ;
            default:    ;
        endcase
    end

    assign err_pulse  = err_q;
    assign err_sticky = sticky_q;
endmodule

// File: rtl/bpar_unit_chk.sv
module bpar_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] addr_data,
    input logic [3:0]  cmd_be,
    input logic        phase_valid,
    input logic        phase_is_addr,
    input logic        is_initiator,
    input logic        is_write,
    input logic        par_in,
    input logic        err_clr,
    input logic        par_out,
    input logic        par_oe,
    input logic        err_pulse,
    input logic        err_sticky
);
    assert_even_R1: assert property (@(posedge clk) disable iff (!rst_n)
        par_oe |-> ((^{$past(addr_data), $past(cmd_be), par_out}) == 1'b0));

    assert_addr_drive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_valid && phase_is_addr && is_initiator) |=> par_oe);

    assert_data_drive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_valid && !phase_is_addr && (is_initiator == is_write)) |=> par_oe);

    assert_no_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_valid && !phase_is_addr && (is_initiator != is_write)) |=> !par_oe);

    assert_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !phase_valid |=> !par_oe);

    assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> ($past(par_in) != (^{$past(addr_data, 2), $past(cmd_be, 2)})));

    assert_only_target_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(phase_valid && !phase_is_addr && !is_initiator && is_write) |=> ##1 !err_pulse);

    assert_sticky_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> err_sticky);

    assert_sticky_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_clr |=> (err_pulse || !err_sticky));

    always_comb begin
        if (!rst_n) begin
            assert_reset_R10: assert (!par_oe && !par_out && !err_pulse && !err_sticky);
        end
    end
endmodule

bind bpar_unit bpar_unit_chk chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .addr_data     (addr_data),
    .cmd_be        (cmd_be),
    .phase_valid   (phase_valid),
    .phase_is_addr (phase_is_addr),
    .is_initiator  (is_initiator),
    .is_write      (is_write),
    .par_in        (par_in),
    .err_clr       (err_clr),
    .par_out       (par_out),
    .par_oe        (par_oe),
    .err_pulse     (err_pulse),
    .err_sticky    (err_sticky)
);

// File: tb/bpar_unit_tb_top.sv
`timescale 1ns/100ps
module bpar_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] addr_data = '0;
    logic [3:0]  cmd_be = '0;
    logic        phase_valid = 1'b0, phase_is_addr = 1'b0;
    logic        is_initiator = 1'b0, is_write = 1'b0;
    logic        par_in = 1'b0, err_clr = 1'b0;
    logic        par_out, par_oe, err_pulse, err_sticky;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    // Reference model state
    bit    m_drv, m_chk, m_par, exp_err, exp_sticky, prev_chk;
    string drv_tag;

    always #2.5 clk = ~clk;

    bpar_unit dut_i (
        .clk (clk), .rst_n (rst_n), .addr_data (addr_data), .cmd_be (cmd_be),
        .phase_valid (phase_valid), .phase_is_addr (phase_is_addr),
        .is_initiator (is_initiator), .is_write (is_write),
        .par_in (par_in), .err_clr (err_clr),
        .par_out (par_out), .par_oe (par_oe),
        .err_pulse (err_pulse), .err_sticky (err_sticky)
    );

    function automatic bit ref_par(input logic [31:0] a, input logic [3:0] c);
        int ones = 0;
        for (int i = 0; i < 32; i++) ones += a[i];
        for (int i = 0; i < 4; i++)  ones += c[i];
        return bit'(ones % 2);
    endfunction

    function automatic bit ref_drive(input bit pv, pa, pi, pw);
        if (!pv) return 1'b0;
        if (pa)  return pi;
        return (pi && pw) || (!pi && !pw);
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    // One bus clock: drive at negedge, predict, compare at the following negedge
    task automatic cyc(input bit pv, pa, pi, pw, input logic [31:0] a,
                       input logic [3:0] c, input bit flip, input bit clr);
        bit n_err;
        phase_valid = pv; phase_is_addr = pa; is_initiator = pi; is_write = pw;
        addr_data = a; cmd_be = c;
        par_in = m_par ^ flip;
        err_clr = clr;
        n_err      = m_chk && (par_in != m_par);
        exp_sticky = n_err || (exp_sticky && !clr);
        exp_err    = n_err;
        prev_chk   = m_chk;
        m_chk      = pv && !pa && !pi && pw;
        m_drv      = ref_drive(pv, pa, pi, pw);
        m_par      = ref_par(a, c);
        if (!pv)     drv_tag = "R6";
        else if (pa) drv_tag = "R3";
        else         drv_tag = m_drv ? "R4" : "R5";
        @(negedge clk);
        check({drv_tag, " R2 par_oe"}, par_oe, m_drv);
        if (m_drv) check("R1 R2 par_out", par_out, m_par);
        check(prev_chk ? "R7 err_pulse" : "R8 err_pulse", err_pulse, exp_err);
        check("R9 err_sticky", err_sticky, exp_sticky);
    endtask

    initial begin
        process::self().srandom(32'd1234);
        repeat (3) @(negedge clk);
        check("R10 par_oe", par_oe, 1'b0);
        check("R10 par_out", par_out, 1'b0);
        check("R10 err_pulse", err_pulse, 1'b0);
        check("R10 err_sticky", err_sticky, 1'b0);
        rst_n = 1'b1;

        // Directed: full 36-bit parity patterns, address phase as initiator
        cyc(1, 1, 1, 0, 32'hFFFF_FFFF, 4'h0, 0, 0);
        cyc(1, 1, 1, 1, 32'h0000_0000, 4'hF, 0, 0);
        cyc(1, 1, 1, 1, 32'h0000_0100, 4'h0, 0, 0);
        cyc(1, 1, 1, 1, 32'h0000_0000, 4'h8, 0, 0);
        cyc(1, 1, 0, 1, 32'h1234_5678, 4'h3, 0, 0);
        // Data phases in each role
        cyc(1, 0, 1, 1, 32'hA5A5_0001, 4'hE, 0, 0);
        cyc(1, 0, 0, 0, 32'h8000_0000, 4'h1, 0, 0);
        cyc(1, 0, 1, 0, 32'h0F0F_0F0F, 4'h7, 0, 0);
        // Wrong parity after an initiator read: ignored
        cyc(1, 0, 0, 1, 32'hDEAD_BEEF, 4'h5, 1, 0);
        // Target write then bad parity, back-to-back target write
        cyc(1, 0, 0, 1, 32'h0000_0003, 4'h0, 1, 0);
        // Error coinciding with clear: error wins
        cyc(0, 0, 0, 0, 32'h0, 4'h0, 1, 1);
        cyc(0, 0, 0, 0, 32'h0, 4'h0, 0, 1);
        cyc(0, 0, 0, 0, 32'h0, 4'h0, 1, 0);

        // Constrained random traffic
        for (int k = 0; k < 2000; k++) begin
            cyc(($urandom % 5) != 0, ($urandom % 3) == 0, $urandom % 2, $urandom % 2,
                $urandom, 4'($urandom), ($urandom % 4) == 0, ($urandom % 10) == 0);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule